// File: doc/BRIEF.md
# Framed Serial Peripheral Master

This block is a serial peripheral master. It shifts characters of a programmable length out on `mosi` and in on `miso`, and it generates `sck`. Transfers use clock polarity 0 and phase 0: `mosi` changes on the falling edge of `sck`, and `miso` is sampled on the rising edge. The slave-select pin `ss` can also serve as a framing signal, and a 3-bit mode field chooses how:

- **Plain mode:** `ss` follows a software-written level (`ssv`). The hardware clears that level when a frame ends.
- **Loopback mode:** the pins stay quiet while the shift register is fed from its own output.
- **Synchronous framing mode:** `ss` changes one SCK period ahead of each frame, and `sck` keeps running so that frames follow one another without a gap.

Software uses three single-cycle write ports. The first writes the configuration byte. The second writes the `ssv` level. The third writes a transmit character into a one-entry holding register. `tx_ready` shows when that holding register is empty.

When a character completes, the block presents it on `rx_data` together with a one-cycle `rx_valid` strobe. In framing mode, `tx_underrun` flags the case where a frame ended and no further data was waiting.

The controller is a four-state machine:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | No transfer in progress. |
| `ST_LEAD` | One SCK period of framing lead, with no data. |
| `ST_SHIFT` | Bits are being shifted. |
| `ST_CLOSE` | One cycle at the end of a plain-mode frame, in which `ssv` is cleared. |

Its transitions are:

- **`ST_IDLE` → `ST_LEAD`:** a character is waiting and the mode is framing.
- **`ST_IDLE` → `ST_SHIFT`:** a character is waiting in any other mode.
- **`ST_LEAD` → `ST_SHIFT`:** on the falling edge that ends the lead period.
- **`ST_SHIFT` → `ST_SHIFT`:** at the last bit, when another character is waiting. That character is loaded with no gap.
- **`ST_SHIFT` → `ST_CLOSE`:** at the last bit with nothing waiting, outside framing mode.
- **`ST_SHIFT` → `ST_IDLE`:** at the last bit with nothing waiting, in framing mode. This is an underrun.
- **`ST_CLOSE` → `ST_IDLE`:** always, after one cycle.

Top module: `spi_frame_master`

## Requirements
- R1: After reset the outputs are as follows:
  - `sck`, `mosi`, `ss`, `rx_valid` and `tx_underrun` are 0.
  - `tx_ready` is 1.
  - Every configuration field is 0.
- R2: The configuration byte has the following layout:

  | Bits | Field |
  |------|-------|
  | 7:5 | mode: 000 plain, 001 loopback, 010 framing |
  | 4:2 | character length |
  | 1 | ss enable |
  | 0 | ss polarity |

  A character length of 0 means 8 bits, and 1 to 7 mean that many bits. Characters are sent most significant bit first. A received character appears in the low bits of `rx_data`.
- R3: In plain mode with ss enable set, `ss` equals `ssv` XOR polarity. `ssv` may be written in the same cycle as the first character. When ss enable is clear, `ss` equals the polarity bit.
- R4: In plain mode, `sck` idles low and gives exactly one rising edge per bit. `mosi` changes on falling edges, and `miso` is sampled on rising edges.
- R5: `rx_valid` pulses for exactly one cycle after the last bit of each character. `rx_data` holds that character.
- R6: When a plain-mode frame ends with no character waiting, `ssv` is cleared by hardware. This takes effect one cycle after the `rx_valid` pulse. If characters are written while the frame is in progress, they continue the frame without deasserting `ss`.
- R7: In loopback mode, `sck` and `mosi` stay 0 and `ss` equals the polarity bit. The received character equals the transmitted one.
- R8: In framing mode, `ss` takes the new frame's `ssv` one full SCK period (2·HALF_DIV clocks) before the first data bit begins. `sck` runs during that lead period.
- R9: In framing mode, when each next character is supplied in time, `sck` runs with a constant period across frame boundaries. `ss` changes at the start of the last bit of the current frame, taking the next frame's `ssv`.
- R10: In framing mode, if a frame ends with no character waiting:
  - `tx_underrun` pulses for one cycle.
  - `sck` stops low.
  - `ss` keeps its last level.
- R11: The mode codes 011 to 111 behave as plain mode.
- R12: `tx_ready` goes low in the cycle after a character write. It returns high once the character has been taken for shifting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte |
| ssv_we | input | 1 | Slave-select level write strobe |
| ssv_wdata | input | 1 | Slave-select level |
| tx_we | input | 1 | Transmit character write strobe |
| tx_wdata | input | 8 | Transmit character, right aligned |
| tx_ready | output | 1 | Holding register empty |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss | output | 1 | Slave-select / frame pin |
| rx_data | output | 8 | Last received character, right aligned |
| rx_valid | output | 1 | One-cycle received-character strobe |
| tx_underrun | output | 1 | One-cycle framing underrun strobe |

## Verification
The bench builds the block with HALF_DIV = 2, so each SCK half period lasts two system clocks. With that setting, the framing lead of one full SCK period can be told apart from a half period, and the spacing between rising edges in back-to-back frames can be measured in clock counts. Characters of 8 and 5 bits are used, so both the full-width and the left-aligned short path are exercised. A reserved mode code is included to confirm that it falls back to plain behaviour.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    localparam int CHAR_W = 8;
    localparam int CNT_W  = $clog2(CHAR_W) + 1;

    localparam logic [2:0] MD_PLAIN = 3'b000;
    localparam logic [2:0] MD_LOOP  = 3'b001;
    localparam logic [2:0] MD_FRAME = 3'b010;

    typedef struct packed {
        logic [2:0] mode;
        logic [2:0] len;
        logic       ss_oe;
        logic       ss_pol;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_CLOSE = 2'd3
    } state_t;

endpackage

// File: rtl/sfm_tick.sv
module sfm_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sfm_shift.sv
module sfm_shift
    import sfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              sample,
    input  logic              advance,
    input  logic              sin,
    output logic              sout,
    output logic [CHAR_W-1:0] rx_word
);
    logic [CHAR_W-1:0] tx_sh;
    logic [CHAR_W-1:0] rx_sh;
    logic [CNT_W-1:0]  pad;

    assign pad     = CNT_W'(CHAR_W) - nbits;
    assign sout    = tx_sh[CHAR_W-1];
    assign rx_word = rx_sh & ({CHAR_W{1'b1}} >> pad);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (load) begin
            tx_sh <= load_data << pad;
        end else if (advance) begin
            tx_sh <= {tx_sh[CHAR_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sh <= '0;
        else if (sample)
            rx_sh <= {rx_sh[CHAR_W-2:0], sin};
    end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import sfm_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              ssv_we,
    input  logic              ssv_wdata,
    input  logic              tx_we,
    input  logic [CHAR_W-1:0] tx_wdata,
    output logic              tx_ready,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              tx_underrun
);
    cfg_t              cfg;
    state_t            state, nxt;
    logic              ssv, ss_frm, sck_r;
    logic              hold_vld, hold_ssv;
    logic [CHAR_W-1:0] hold_data;
    logic [CNT_W-1:0]  bit_cnt, nbits;
    logic              tick, rise, fall, last, run;
    logic              load, sample, advance, done;
    logic              sout, sin;
    logic [CHAR_W-1:0] rx_word;
    logic              is_loop, is_frame, ssv_now;
    logic [2:0]        cfg_mode;
    logic              st_idle, st_close;

    assign cfg_mode = cfg.mode;
    assign is_loop  = (cfg.mode == MD_LOOP);
    assign is_frame = (cfg.mode == MD_FRAME);
    assign nbits    = (cfg.len == 3'd0) ? CNT_W'(CHAR_W) : CNT_W'(cfg.len);
    assign run      = (state == ST_LEAD) || (state == ST_SHIFT);
    assign st_idle  = (state == ST_IDLE);
    assign st_close = (state == ST_CLOSE);
    assign rise     = tick && !sck_r;
    assign fall     = tick && sck_r;
    assign last     = (bit_cnt == nbits - 1'b1);
    assign sample   = (state == ST_SHIFT) && rise;
    assign advance  = (state == ST_SHIFT) && fall && !last;
    assign done     = (state == ST_SHIFT) && fall && last;
    assign sin      = is_loop ? sout : miso;
    assign ssv_now  = ssv_we ? ssv_wdata : ssv;

    sfm_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    sfm_shift u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(hold_data),
        .nbits(nbits), .sample(sample), .advance(advance), .sin(sin),
        .sout(sout), .rx_word(rx_word)
    );

    // next-state logic
    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (hold_vld) begin
                    load = 1'b1;
                    nxt  = is_frame ? ST_LEAD : ST_SHIFT;
                end
            end
            ST_LEAD: begin
                if (fall) nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (done) begin
                    if (hold_vld) begin
                        load = 1'b1;
                        nxt  = ST_SHIFT;
                    end else begin
                        nxt = is_frame ? ST_IDLE : ST_CLOSE;
                    end
                end
            end
            ST_CLOSE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg         <= '0;
            ssv         <= 1'b0;
            ss_frm      <= 1'b0;
            sck_r       <= 1'b0;
            hold_vld    <= 1'b0;
            hold_ssv    <= 1'b0;
            hold_data   <= '0;
            bit_cnt     <= '0;
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            tx_underrun <= 1'b0;
        end else begin
            if (cfg_we) cfg <= cfg_t'(cfg_wdata);

            if (state == ST_CLOSE)  ssv <= 1'b0;
            else if (ssv_we)        ssv <= ssv_wdata;

            if (load) hold_vld <= 1'b0;
            if (tx_we && !hold_vld) begin
                hold_vld  <= 1'b1;
                hold_data <= tx_wdata;
                hold_ssv  <= ssv_now;
            end

            if (!run)      sck_r <= 1'b0;
            else if (tick) sck_r <= ~sck_r;

            if (load)         bit_cnt <= '0;
            else if (advance) bit_cnt <= bit_cnt + 1'b1;

            if (is_frame && hold_vld) begin
                if (state == ST_IDLE)
                    ss_frm <= hold_ssv;
                else if (advance && (bit_cnt + 1'b1 == nbits - 1'b1))
                    ss_frm <= hold_ssv;
            end

            rx_valid    <= done;
            tx_underrun <= done && is_frame && !hold_vld;
            if (done) rx_data <= rx_word;
        end
    end

    // pin drive
    always_comb begin
        tx_ready = !hold_vld;
        sck      = is_loop ? 1'b0 : sck_r;
        mosi     = (run && !is_loop) ? sout : 1'b0;
        if (!cfg.ss_oe || is_loop) ss = cfg.ss_pol;
        else if (is_frame)         ss = ss_frm ^ cfg.ss_pol;
        else                       ss = ssv ^ cfg.ss_pol;
    end
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       ss_oe,
    input logic       ss_pol,
    input logic       cfg_we,
    input logic       ssv,
    input logic       ssv_we,
    input logic       ssv_wdata,
    input logic       st_idle,
    input logic       st_close,
    input logic       run,
    input logic       sck,
    input logic       mosi,
    input logic       ss,
    input logic       rx_valid,
    input logic       tx_underrun
);
    // R7: loopback keeps the pins quiet
    p_loop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b001) |-> (!sck && !mosi && (ss == ss_pol)));

    // R3: a level write reaches the pin on the next cycle in plain mode
    p_ss_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ssv_we && (mode == 3'b000) && ss_oe && !cfg_we && !st_close)
        |=> (ss == (ssv_wdata ^ ss_pol)));

    // R5: the receive strobe lasts one cycle
    p_rxv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6: hardware clearing of the level follows a receive strobe
    p_ssv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ssv) && !$past(ssv_we)) |-> $past(rx_valid));

    // R6: the close cycle leaves the level cleared
    p_close_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_close |=> !ssv);

    // R4: no clock while nothing is being shifted
    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !sck);

    // R10: an underrun leaves the clock stopped
    p_underrun_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> !sck);

    // R10: the frame pin holds while idle in framing mode
    p_frame_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'b010) && st_idle && $past(st_idle) && !$past(cfg_we)
         && ($past(mode) == 3'b010)) |-> $stable(ss));
endmodule

bind spi_frame_master sfm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .ss_oe(cfg.ss_oe),
    .ss_pol(cfg.ss_pol), .cfg_we(cfg_we), .ssv(ssv), .ssv_we(ssv_we),
    .ssv_wdata(ssv_wdata), .st_idle(st_idle), .st_close(st_close),
    .run(run), .sck(sck), .mosi(mosi), .ss(ss), .rx_valid(rx_valid),
    .tx_underrun(tx_underrun)
);

// File: tb/sim_spi_frame_master.sv
module sim_spi_frame_master;
    localparam int HD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, ssv_we = 1'b0, ssv_wdata = 1'b0, tx_we = 1'b0;
    logic [7:0] cfg_wdata = '0, tx_wdata = '0;
    logic       tx_ready, sck, mosi, miso, ss, rx_valid, tx_underrun;
    logic [7:0] rx_data;

    int errors = 0, checks = 0, cyc = 0;
    int rise_cnt = 0, last_rise = -1, max_gap = 0, first_rise = -1;
    int ss_chg_cyc = 0, ss_chg_rises = 0;
    logic [7:0] mosi_cap = '0, slv_sh = '0;

    always #10 clk = ~clk;

    spi_frame_master #(.HALF_DIV(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ssv_we(ssv_we), .ssv_wdata(ssv_wdata), .tx_we(tx_we),
        .tx_wdata(tx_wdata), .tx_ready(tx_ready), .sck(sck), .mosi(mosi),
        .miso(miso), .ss(ss), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_underrun(tx_underrun)
    );

    assign miso = slv_sh[7];

    always @(negedge clk) cyc = cyc + 1;
    always @(negedge sck) slv_sh = {slv_sh[6:0], 1'b0};
    always @(posedge sck) begin
        mosi_cap = {mosi_cap[6:0], mosi};
        rise_cnt = rise_cnt + 1;
        if (first_rise < 0) first_rise = cyc;
        if (last_rise >= 0 && (cyc - last_rise) > max_gap) max_gap = cyc - last_rise;
        last_rise = cyc;
    end
    always @(ss) begin
        ss_chg_cyc   = cyc;
        ss_chg_rises = rise_cnt;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic wr_ssv(input logic v);
        @(negedge clk); ssv_we = 1'b1; ssv_wdata = v;
        @(negedge clk); ssv_we = 1'b0;
    endtask

    task automatic wr_tx(input logic [7:0] d, input logic set_ssv, input logic v);
        @(negedge clk); tx_we = 1'b1; tx_wdata = d; ssv_we = set_ssv; ssv_wdata = v;
        @(negedge clk); tx_we = 1'b0; ssv_we = 1'b0;
    endtask

    task automatic wait_rxv(input string req);
        int n = 0;
        while (!rx_valid && n < 2000) begin @(negedge clk); n++; end
        if (!rx_valid) chk({req, " rx_valid timeout"}, 0, 1);
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!tx_ready && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 sck", sck, 0);
        chk("R1 mosi", mosi, 0);
        chk("R1 ss", ss, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 underrun", tx_underrun, 0);
        chk("R1 tx_ready", tx_ready, 1);
    endtask

    task automatic t_plain8();
        int r0;
        wr_cfg(8'h02);
        slv_sh = 8'h3C;
        r0 = rise_cnt;
        wr_tx(8'hA5, 1'b1, 1'b1);
        chk("R3 ss follows level", ss, 1);
        chk("R12 tx_ready low after write", tx_ready, 0);
        wait_rxv("R5");
        chk("R5 rx_data", rx_data, 8'h3C);
        chk("R2 msb first mosi", mosi_cap, 8'hA5);
        chk("R4 rising edges", rise_cnt - r0, 8);
        chk("R6 ss held during strobe", ss, 1);
        @(negedge clk);
        chk("R5 strobe one cycle", rx_valid, 0);
        chk("R6 level cleared", ss, 0);
        chk("R4 sck idle low", sck, 0);
    endtask

    task automatic t_plain5();
        int r0;
        wr_cfg(8'h17);
        chk("R3 ss deasserted high with polarity", ss, 1);
        wr_ssv(1'b1);
        chk("R3 inverted ss", ss, 0);
        slv_sh = 8'h50;
        r0 = rise_cnt;
        wr_tx(8'h13, 1'b0, 1'b0);
        wait_rxv("R2");
        chk("R2 5-bit rx", rx_data, 8'h0A);
        chk("R2 5-bit mosi", mosi_cap & 8'h1F, 8'h13);
        chk("R4 5 rising edges", rise_cnt - r0, 5);
        @(negedge clk);
        chk("R6 ss back to idle level", ss, 1);
    endtask

    task automatic t_plain_b2b();
        int pulses = 0, drops = 0, n = 0;
        wr_cfg(8'h02);
        slv_sh = 8'h99;
        wr_tx(8'h11, 1'b1, 1'b1);
        wait_ready();
        chk("R12 tx_ready returns", tx_ready, 1);
        wr_tx(8'h22, 1'b0, 1'b0);
        while (pulses < 2 && n < 4000) begin
            @(negedge clk); n++;
            if (rx_valid) pulses++;
            if (!ss) drops++;
        end
        chk("R5 two strobes", pulses, 2);
        chk("R6 ss kept through both characters", drops, 0);
        chk("R2 second character", mosi_cap, 8'h22);
        @(negedge clk);
        chk("R6 cleared after last", ss, 0);
    endtask

    task automatic t_reserved();
        int r0;
        wr_cfg(8'hE2);
        slv_sh = 8'hF0;
        r0 = rise_cnt;
        wr_tx(8'h5A, 1'b1, 1'b1);
        chk("R11 ss follows level", ss, 1);
        wait_rxv("R11");
        chk("R11 rx", rx_data, 8'hF0);
        chk("R11 mosi", mosi_cap, 8'h5A);
        chk("R11 edges", rise_cnt - r0, 8);
        @(negedge clk);
        chk("R11 ss cleared", ss, 0);
    endtask

    task automatic t_loop();
        int r0, bad = 0, n = 0;
        wr_cfg(8'h23);
        slv_sh = 8'h00;
        r0 = rise_cnt;
        wr_tx(8'h6B, 1'b1, 1'b1);
        while (!rx_valid && n < 2000) begin
            if (sck || mosi || !ss) bad++;
            @(negedge clk); n++;
        end
        chk("R7 pins quiet", bad, 0);
        chk("R7 no sck edges", rise_cnt - r0, 0);
        chk("R7 echoed data", rx_data, 8'h6B);
    endtask

    task automatic t_frame();
        int r0, c0, n = 0;
        wr_cfg(8'h42);
        wr_ssv(1'b0);
        r0 = rise_cnt; max_gap = 0; last_rise = -1; first_rise = -1;
        wr_tx(8'h81, 1'b1, 1'b1);
        while (!ss && n < 100) begin @(negedge clk); n++; end
        c0 = ss_chg_cyc;
        wr_tx(8'h7E, 1'b1, 1'b0);
        n = 0;
        while (rise_cnt - r0 < 2 && n < 200) begin @(negedge clk); n++; end
        chk("R8 sck runs in lead", first_rise - c0, HD);
        chk("R8 data one SCK period after ss", last_rise - c0, 3 * HD);
        n = 0;
        while (ss && n < 400) begin @(negedge clk); n++; end
        chk("R9 ss change at last bit of frame 1", ss_chg_rises - r0, 8);
        wait_ready();
        wr_tx(8'hC3, 1'b1, 1'b1);
        n = 0;
        while (!ss && n < 400) begin @(negedge clk); n++; end
        chk("R9 ss change at last bit of frame 2", ss_chg_rises - r0, 16);
        n = 0;
        while (!tx_underrun && n < 400) begin @(negedge clk); n++; end
        chk("R10 underrun strobe", tx_underrun, 1);
        chk("R10 ss held", ss, 1);
        chk("R9 no gap between frames", max_gap, 2 * HD);
        chk("R9 total edges", rise_cnt - r0, 25);
        chk("R9 last frame data", mosi_cap, 8'hC3);
        @(negedge clk);
        chk("R10 strobe one cycle", tx_underrun, 0);
        c0 = rise_cnt;
        repeat (10) @(negedge clk);
        chk("R10 sck stopped", rise_cnt - c0, 0);
        chk("R10 sck low", sck, 0);
        chk("R10 ss still held", ss, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain8();
        t_plain5();
        t_plain_b2b();
        t_reserved();
        t_loop();
        t_frame();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule